// File: doc/BRIEF.md
# Audio Converter Status Flag Register

This block is an 8-bit read-only status register for a two-channel audio converter. Each channel, left and right, reports three conditions. The first says that the programmable gain stage has settled, meaning the applied gain equals the programmed gain. The second says that the converter is powered up. The third says that the automatic gain control has reached its maximum allowed gain. The settled and powered bits follow their live sources. The saturation bits are sticky event flags.

All six status inputs may arrive from other clock domains, so each one passes through a synchronizer before the register uses it. A saturation flag is set by a fresh 0-to-1 transition of its synchronized source. It stays set until the register is read. The read that observes the flag clears it at the end of that read cycle, so the read still returns the value from before the clear. If a new transition arrives in the same cycle as the clearing read, the flag stays set and the event is kept. The register decodes a write strobe and discards it, so writes leave every bit unchanged.

Top module: `audstat_flags`

## Requirements
- R1: While reset is held and after it is released with all sources low, the read data is 8'h00.
- R2: Bit 7 (left) and bit 3 (right) show the gain-settled sources. A change on a source reaches the read data after exactly two rising clock edges.
- R3: Bit 6 (left) and bit 2 (right) show the powered-up sources, with the same two-edge latency as R2.
- R4: Bits 4 and 0 are reserved and always read as 0.
- R5: Bit 5 (left) and bit 1 (right) are saturation flags. Each is set on the third rising edge after its source goes from 0 to 1, and it stays set after the source returns to 0.
- R6: In a cycle where the read strobe is high, the read data shows the saturation flags as they were before the read. Both flags are cleared on the clock edge that ends that cycle.
- R7: After a clear, a saturation flag stays 0 while its source remains high. It sets again only when the source falls and then rises again.
- R8: If the rising edge that sets a flag falls in the same cycle as a clearing read, the flag remains 1 after that cycle.
- R9: A write strobe, with any write data, has no effect on any bit of the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| left_settled_i | input | 1 | Left applied gain equals programmed gain (asynchronous) |
| left_powered_i | input | 1 | Left converter powered up (asynchronous) |
| left_sat_i | input | 1 | Left gain control at maximum gain (asynchronous) |
| right_settled_i | input | 1 | Right applied gain equals programmed gain (asynchronous) |
| right_powered_i | input | 1 | Right converter powered up (asynchronous) |
| right_sat_i | input | 1 | Right gain control at maximum gain (asynchronous) |
| rd_stb_i | input | 1 | One-cycle read of the register; clears the saturation flags |
| wr_stb_i | input | 1 | Write strobe, accepted and discarded |
| wr_data_i | input | 8 | Write data, discarded |
| rd_data_o | output | 8 | Current register contents |

## Verification
The properties assume that every source level lasts at least one clock cycle after synchronization. If a pulse is shorter than that, the synchronizer may miss it, and the flag correctly never sets, so the properties are written in terms of the internal edge-detect signal and not the raw pin. They also assume that a read strobe is a clean one-cycle level sampled on the clock. The bench changes sources and strobes only on falling edges and holds each source level for at least three cycles. Its read strobes are single cycles, timed either well clear of a source edge or placed deliberately on the cycle where the detected edge is active.

// File: rtl/audstat_pkg.sv
// Shared constants and types for the audio status flag register.
// Assumes two channels; channel 0 maps to the upper nibble, channel 1 to the lower.
package audstat_pkg;
    localparam int NUM_CH      = 2;
    localparam int BITS_PER_CH = 3;
    localparam int REG_W       = 8;
    localparam int NIBBLE_W    = REG_W / NUM_CH;

    // Per-channel status sources in a fixed order.
    typedef struct packed {
        logic settled;
        logic powered;
        logic saturated;
    } ch_stat_t;

    // Bit index of a channel's most significant field in the register.
    function automatic int ch_base(input int ch);
        return REG_W - 1 - ch * NIBBLE_W;
    endfunction
endpackage

// File: rtl/audstat_sync.sv
// Multi-stage level synchronizer for a vector of independent status bits.
// Assumes each bit is a slow level; no bus coherence between bits is implied.
module audstat_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stg_q [STAGES];

    // Shift the raw levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[LAST];
endmodule

// File: rtl/audstat_sticky.sv
// Rising-edge detection and sticky event flags with clear-on-read.
// Assumes sources are already synchronized. A set coinciding with a clear wins.
module audstat_sticky #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         clr_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;

    // Remember last cycle's source level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_i;
    end

    assign rise_o = src_i & ~prev_q;

    generate
        for (genvar b = 0; b < W; b++) begin : g_flag
            // Set on a new edge, otherwise clear on read, otherwise hold.
            always_ff @(posedge clk) begin
                if (!rst_n)         flag_q[b] <= 1'b0;
                else if (rise_o[b]) flag_q[b] <= 1'b1;
                else if (clr_i)     flag_q[b] <= 1'b0;
            end
        end
    endgenerate

    assign flag_o = flag_q;
endmodule

// File: rtl/audstat_flags.sv
// Top of the audio status flag register: synchronizes six status sources,
// presents live and sticky bits on an 8-bit read bus, clears sticky bits on read.
// Assumes rd_stb_i is a one-cycle pulse per register read; writes are discarded.
module audstat_flags
    import audstat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       left_settled_i,
    input  logic       left_powered_i,
    input  logic       left_sat_i,
    input  logic       right_settled_i,
    input  logic       right_powered_i,
    input  logic       right_sat_i,
    input  logic       rd_stb_i,
    input  logic       wr_stb_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o
);
    localparam int RAW_W = NUM_CH * BITS_PER_CH;

    ch_stat_t [NUM_CH-1:0] raw_st;
    ch_stat_t [NUM_CH-1:0] syn_st;
    logic [NUM_CH-1:0]     sat_src;
    logic [NUM_CH-1:0]     sat_rise;
    logic [NUM_CH-1:0]     sat_flag;
    logic                  wr_unused;

    // Collect raw inputs per channel.
    assign raw_st[0] = '{settled: left_settled_i,  powered: left_powered_i,  saturated: left_sat_i};
    assign raw_st[1] = '{settled: right_settled_i, powered: right_powered_i, saturated: right_sat_i};

    // Writes are accepted and discarded.
    assign wr_unused = ^{wr_stb_i, wr_data_i};

    audstat_sync #(
        .W      (RAW_W),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_st),
        .sync_o  (syn_st)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_src
            assign sat_src[c] = syn_st[c].saturated;
        end
    endgenerate

    audstat_sticky #(
        .W (NUM_CH)
    ) sticky_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (sat_src),
        .clr_i  (rd_stb_i),
        .rise_o (sat_rise),
        .flag_o (sat_flag)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_map
            localparam int B = ch_base(c);
            assign rd_data_o[B]   = syn_st[c].settled;
            assign rd_data_o[B-1] = syn_st[c].powered;
            assign rd_data_o[B-2] = sat_flag[c];
            assign rd_data_o[B-3] = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/audstat_flags_chk.sv
// Property checker for audstat_flags, bound to every instance of the top.
// Assumes it sees the internal edge-detect vector from the sticky stage.
module audstat_flags_chk
    import audstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb_i,
    input logic [7:0]        rd_data_o,
    input logic [NUM_CH-1:0] sat_rise
);
    // R4: reserved bits never read as 1.
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[4] == 1'b0) && (rd_data_o[0] == 1'b0));

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam int S = ch_base(c) - 2;

            // R5: a detected edge leaves the flag set next cycle.
            a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
                sat_rise[c] |=> rd_data_o[S]);

            // R5: the flag only turns on because of a detected edge.
            a_r5_set_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rd_data_o[S]) |-> $past(sat_rise[c]));

            // R6: a read with no coinciding edge clears the flag.
            a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_stb_i && !sat_rise[c]) |=> !rd_data_o[S]);

            // R7: with no read and no edge the flag holds its value.
            a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (!rd_stb_i && !sat_rise[c]) |=> $stable(rd_data_o[S]));

            // R8: an edge during a read still leaves the flag set.
            a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_stb_i && sat_rise[c]) |=> rd_data_o[S]);
        end
    endgenerate
endmodule

bind audstat_flags audstat_flags_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb_i  (rd_stb_i),
    .rd_data_o (rd_data_o),
    .sat_rise  (sat_rise)
);

// File: tb/audstat_flags_tb_top.sv
`timescale 1ns/1ps
// Directed bench for audstat_flags: one task per scenario, each self-checking.
module audstat_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_set = 1'b0, l_pwr = 1'b0, l_sat = 1'b0;
    logic       r_set = 1'b0, r_pwr = 1'b0, r_sat = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    audstat_flags dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .left_settled_i  (l_set),
        .left_powered_i  (l_pwr),
        .left_sat_i      (l_sat),
        .right_settled_i (r_set),
        .right_powered_i (r_pwr),
        .right_sat_i     (r_sat),
        .rd_stb_i        (rd_stb),
        .wr_stb_i        (wr_stb),
        .wr_data_i       (wr_data),
        .rd_data_o       (rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle read; returns the value seen while the strobe is high.
    task automatic do_read(output logic [7:0] seen);
        rd_stb = 1'b1;
        #1 seen = rd_data;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 during reset", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        wait_n(3);
        check("R1 after reset", rd_data, 8'h00);
    endtask

    task automatic t_live;
        l_set = 1'b1;
        wait_n(1);
        check("R2 one edge latency", rd_data, 8'h00);
        wait_n(1);
        check("R2 left settled", rd_data, 8'h80);
        r_pwr = 1'b1;
        wait_n(2);
        check("R3 right powered", rd_data, 8'h84);
        l_pwr = 1'b1; r_set = 1'b1;
        wait_n(2);
        check("R2 R3 all live", rd_data, 8'hCC);
        check("R4 reserved", rd_data & 8'h11, 8'h00);
        l_set = 1'b0; l_pwr = 1'b0; r_set = 1'b0; r_pwr = 1'b0;
        wait_n(2);
        check("R2 R3 live fall", rd_data, 8'h00);
    endtask

    task automatic t_sticky_and_clear;
        logic [7:0] seen;
        l_sat = 1'b1;
        wait_n(2);
        check("R5 not yet set", rd_data, 8'h00);
        wait_n(1);
        check("R5 left set", rd_data, 8'h20);
        l_sat = 1'b0;
        wait_n(4);
        check("R5 left held", rd_data, 8'h20);
        do_read(seen);
        check("R6 read pre-clear", seen, 8'h20);
        check("R6 cleared", rd_data, 8'h00);
        r_sat = 1'b1;
        wait_n(3);
        r_sat = 1'b0;
        wait_n(3);
        check("R5 right set", rd_data, 8'h02);
        check("R4 reserved", rd_data & 8'h11, 8'h00);
        do_read(seen);
        check("R6 right pre-clear", seen, 8'h02);
        check("R6 right cleared", rd_data, 8'h00);
    endtask

    task automatic t_no_retrigger;
        logic [7:0] seen;
        l_sat = 1'b1;
        wait_n(3);
        do_read(seen);
        check("R7 read while high", seen, 8'h20);
        wait_n(5);
        check("R7 held high no reset", rd_data, 8'h00);
        l_sat = 1'b0;
        wait_n(3);
        check("R7 falling no set", rd_data, 8'h00);
        l_sat = 1'b1;
        wait_n(3);
        check("R7 new edge sets", rd_data, 8'h20);
        l_sat = 1'b0;
        wait_n(3);
        do_read(seen);
        check("R7 cleanup", rd_data, 8'h00);
    endtask

    task automatic t_coincide;
        logic [7:0] seen;
        l_sat = 1'b1;
        wait_n(3);
        l_sat = 1'b0;
        wait_n(3);
        check("R8 preset", rd_data, 8'h20);
        l_sat = 1'b1;
        wait_n(2);
        do_read(seen);
        check("R8 read value", seen, 8'h20);
        check("R8 kept on coincide", rd_data, 8'h20);
        wait_n(1);
        check("R8 still set", rd_data, 8'h20);
        l_sat = 1'b0;
        wait_n(3);
        do_read(seen);
        check("R8 cleanup", rd_data, 8'h00);
    endtask

    task automatic t_writes;
        logic [7:0] seen;
        l_set = 1'b1; l_pwr = 1'b1; r_sat = 1'b1;
        wait_n(3);
        r_sat = 1'b0;
        wait_n(3);
        check("R9 before writes", rd_data, 8'hC2);
        wr_stb = 1'b1; wr_data = 8'h00;
        wait_n(1);
        wr_data = 8'hFF;
        wait_n(1);
        wr_stb = 1'b0;
        wait_n(2);
        check("R9 writes ignored", rd_data, 8'hC2);
        l_set = 1'b0; l_pwr = 1'b0;
        wait_n(2);
        do_read(seen);
        check("R9 final", rd_data, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all R) actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_live();
        t_sticky_and_clear();
        t_no_retrigger();
        t_coincide();
        t_writes();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule